// File: doc/BRIEF.md
# PCIe Controller Interrupt Cause and Link Status Unit

This glue block sits next to a PCIe controller core. It turns local event pulses into sticky cause bits. Two of its cause banks carry general events, and the legacy INTx assertions A to D feed the first of these two. A third bank carries error events. Each bank has a mask register of its own. The two general banks together drive one interrupt line, and the error bank drives a separate line. Software clears cause bits by writing ones, normally by writing back the value it just read.

The block also registers two raw link indications, one from the data-link layer and one from the PHY. It reports them in a status register and asserts a link-up flag only when both are present. A control register holds a 4-bit device-mode field and a training-enable bit, and both are driven out as pins. Register access uses a plain single-cycle read/write port with registered read data. No data stream passes through the block, so none of its interfaces has valid/ready handshaking.

Top module: `pcie_irq_link_unit`

## Requirements
- R1: After reset every cause, mask and control bit is 0, and `irq`, `err_irq`, `link_up`, `ltssm_en`, `dev_mode` and `rd_data` are 0.
- R2: An event pulse sets its cause bit at the next clock edge. The bit then stays set until a write clears it.
- R3: The `intx[0..3]` inputs (INTA..INTD) set bits 9, 10, 11 and 12 of cause bank 1 (byte address 0x801C). Cause bank 2 is at 0x8024 and the error cause bank is at 0x802C.
- R4: A write to a cause address clears exactly the bits that are 1 in the write data. If an event arrives in the same cycle as a clear of the same bit, the bit ends up set.
- R5: The mask registers at 0x8020 (bank 1), 0x8028 (bank 2) and 0x8030 (error) hold all 32 written bits and read them back. A mask bit of 1 enables the matching cause bit.
- R6: `irq` is high exactly when some bit is set in both cause 1 and mask 1, or in both cause 2 and mask 2.
- R7: `err_irq` is high exactly when some error cause bit and its error mask bit are both set. An error mask of 0 keeps `err_irq` low.
- R8: The status register at 0x8008 reads the registered data-link indication at bit 1 and the registered PHY indication at bit 9. All its other bits read 0 and writes to it are ignored. `link_up` is high only when both registered indications are 1.
- R9: The control register at 0x8000 stores bit 2 (training enable, driven on `ltssm_en`) and bits 7:4 (device mode, driven on `dev_mode`, where 4 means root complex). All its other bits read 0.
- R10: Read data appears on `rd_data` one cycle after `rd_en` and shows the register values from before that clock edge. Any address not listed above reads 0, and a write to such an address changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 16 | Byte address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| intx | input | 4 | INTA..INTD assertion pulses |
| evt1 | input | 32 | Event pulses for cause bank 1 |
| evt2 | input | 32 | Event pulses for cause bank 2 |
| err_evt | input | 32 | Error event pulses |
| dl_up_raw | input | 1 | Raw data-link-up indication |
| phy_up_raw | input | 1 | Raw PHY-link-up indication |
| irq | output | 1 | Combined general interrupt |
| err_irq | output | 1 | Error interrupt |
| link_up | output | 1 | Both link indications present |
| ltssm_en | output | 1 | Training enable |
| dev_mode | output | 4 | Device-mode field |

## Verification
A cause bit that fails to stick, or that a write does not clear, shows up on `irq` or `err_irq` one cycle after the event or the write. The next read of the bank shows it too, one cycle after `rd_en`. A mask bit stored wrongly or a wrong INTx bit position shows up on the interrupt lines when a lone event is raised into a single enabled bit. A link indication that is swapped or missed shows up on `link_up` and in the status bits one cycle after the raw inputs change. The bench runs a reference model in lockstep over random events, writes and reads. It adds directed cases for a clear and an event in the same cycle, a zero error mask, every link combination and unmapped addresses.

// File: rtl/pcie_irq_link_pkg.sv
package pcie_irq_link_pkg;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 16;
  localparam int N_BANKS = 3;
  localparam int INTX_N  = 4;
  localparam int INTX_LSB = 9;
  localparam int DL_BIT  = 1;
  localparam int PHY_BIT = 9;
  localparam int LTSSM_BIT = 2;
  localparam int MODE_LSB = 4;
  localparam int MODE_W  = 4;
  localparam logic [ADDR_W-1:0] A_CTRL   = 16'h8000;
  localparam logic [ADDR_W-1:0] A_STATUS = 16'h8008;
  localparam logic [ADDR_W-1:0] A_CAUSE [N_BANKS] = '{16'h801C, 16'h8024, 16'h802C};
  localparam logic [ADDR_W-1:0] A_MASK  [N_BANKS] = '{16'h8020, 16'h8028, 16'h8030};
endpackage

// File: rtl/cause_bank.sv
module cause_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         clr_en,
  input  logic         mask_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cause,
  output logic [W-1:0] mask,
  output logic         hit
);
  logic [W-1:0] clr_bits;
  assign clr_bits = clr_en ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause <= '0;
      mask  <= '0;
    end else begin
      cause <= (cause & ~clr_bits) | evt;
      if (mask_en) mask <= wdata;
    end
  end

  assign hit = |(cause & mask);

  // R2: a pulsed event is recorded at the next edge
  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((cause & $past(evt)) == $past(evt)));
  // R2: without events or clears the bank keeps its state
  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_en && evt == '0) |=> $stable(cause));
  // R4: cleared bits without a competing event end up zero
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((cause & $past(wdata & ~evt)) == '0));
endmodule

// File: rtl/link_mon.sv
module link_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic dl_raw,
  input  logic phy_raw,
  output logic dl_q,
  output logic phy_q,
  output logic up
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dl_q  <= 1'b0;
      phy_q <= 1'b0;
      up    <= 1'b0;
    end else begin
      dl_q  <= dl_raw;
      phy_q <= phy_raw;
      up    <= dl_raw & phy_raw;
    end
  end

  // R8: link reported up only if both raw inputs were present one edge before
  assert_link_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
    up |-> ($past(dl_raw) && $past(phy_raw)));
endmodule

// File: rtl/pcie_irq_link_unit.sv
module pcie_irq_link_unit
  import pcie_irq_link_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic [INTX_N-1:0] intx,
  input  logic [REG_W-1:0]  evt1,
  input  logic [REG_W-1:0]  evt2,
  input  logic [REG_W-1:0]  err_evt,
  input  logic              dl_up_raw,
  input  logic              phy_up_raw,
  output logic              irq,
  output logic              err_irq,
  output logic              link_up,
  output logic              ltssm_en,
  output logic [MODE_W-1:0] dev_mode
);
  localparam logic [REG_W-1:0] CTRL_KEEP =
    (REG_W'(1) << LTSSM_BIT) | (REG_W'((1 << MODE_W) - 1) << MODE_LSB);

  logic [REG_W-1:0] bank_evt   [N_BANKS];
  logic [REG_W-1:0] bank_cause [N_BANKS];
  logic [REG_W-1:0] bank_mask  [N_BANKS];
  logic [N_BANKS-1:0] bank_hit;
  logic [REG_W-1:0] ctrl_q;
  logic dl_q, phy_q;

  assign bank_evt[0] = evt1 | (REG_W'(intx) << INTX_LSB);
  assign bank_evt[1] = evt2;
  assign bank_evt[2] = err_evt;

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    cause_bank #(.W(REG_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (bank_evt[b]),
      .clr_en  (wr_en && addr == A_CAUSE[b]),
      .mask_en (wr_en && addr == A_MASK[b]),
      .wdata   (wr_data),
      .cause   (bank_cause[b]),
      .mask    (bank_mask[b]),
      .hit     (bank_hit[b])
    );
  end

  link_mon u_link (
    .clk     (clk),
    .rst_n   (rst_n),
    .dl_raw  (dl_up_raw),
    .phy_raw (phy_up_raw),
    .dl_q    (dl_q),
    .phy_q   (phy_q),
    .up      (link_up)
  );

  assign irq     = bank_hit[0] | bank_hit[1];
  assign err_irq = bank_hit[2];

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_en && addr == A_CTRL) ctrl_q <= wr_data & CTRL_KEEP;
  end
  assign ltssm_en = ctrl_q[LTSSM_BIT];
  assign dev_mode = ctrl_q[MODE_LSB +: MODE_W];

  logic [REG_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (addr == A_CTRL) rd_mux = ctrl_q;
    if (addr == A_STATUS) begin
      rd_mux[DL_BIT]  = dl_q;
      rd_mux[PHY_BIT] = phy_q;
    end
    for (int b = 0; b < N_BANKS; b++) begin
      if (addr == A_CAUSE[b]) rd_mux = bank_cause[b];
      if (addr == A_MASK[b])  rd_mux = bank_mask[b];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  logic unmapped;
  assign unmapped = addr != A_CTRL && addr != A_STATUS &&
    addr != A_CAUSE[0] && addr != A_CAUSE[1] && addr != A_CAUSE[2] &&
    addr != A_MASK[0] && addr != A_MASK[1] && addr != A_MASK[2];

  // R6: no enabled source means no general interrupt
  assert_irq_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_mask[0] == '0 && bank_mask[1] == '0) |-> !irq);
  // R7: zero error mask keeps the error line low
  assert_err_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_mask[2] == '0) |-> !err_irq);
  // R10: unmapped reads return zero
  assert_unmapped_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && unmapped) |=> (rd_data == '0));
  // R9: control outputs only move on a control write
  assert_ctrl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_CTRL) |=> ($stable(ltssm_en) && $stable(dev_mode)));
endmodule

// File: tb/tb_pcie_irq_link_unit.sv
module tb_pcie_irq_link_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0;
  logic [15:0] addr = 0;
  logic [31:0] wr_data = 0, evt1 = 0, evt2 = 0, err_evt = 0;
  logic [3:0] intx = 0;
  logic dl = 0, phy = 0;
  logic [31:0] rd_data;
  logic irq, err_irq, link_up, ltssm_en;
  logic [3:0] dev_mode;

  pcie_irq_link_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .intx(intx), .evt1(evt1),
    .evt2(evt2), .err_evt(err_evt), .dl_up_raw(dl), .phy_up_raw(phy),
    .irq(irq), .err_irq(err_irq), .link_up(link_up), .ltssm_en(ltssm_en),
    .dev_mode(dev_mode));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  // reference model
  logic [31:0] c[3], m[3], ctl, exp_rd;
  logic mdl, mphy;
  localparam logic [15:0] ADDRS [10] = '{16'h8000, 16'h8008, 16'h801C, 16'h8020,
    16'h8024, 16'h8028, 16'h802C, 16'h8030, 16'h8004, 16'h8034};

  function automatic logic [31:0] model_read(input logic [15:0] a);
    case (a)
      16'h8000: return ctl;
      16'h8008: return (32'(mdl) << 1) | (32'(mphy) << 9);
      16'h801C: return c[0];
      16'h8020: return m[0];
      16'h8024: return c[1];
      16'h8028: return m[1];
      16'h802C: return c[2];
      16'h8030: return m[2];
      default:  return 32'h0;
    endcase
  endfunction

  function automatic logic exp_irq();
    return |((c[0] & m[0]) | (c[1] & m[1]));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int b = 0; b < 3; b++) begin c[b] = 0; m[b] = 0; end
    ctl = 0; mdl = 0; mphy = 0; exp_rd = 0;
  endtask

  // one clock: inputs already set; update model, then compare
  task automatic step(input string req);
    logic [31:0] ev[3];
    @(posedge clk);
    ev[0] = evt1 | (32'(intx) << 9); ev[1] = evt2; ev[2] = err_evt;
    if (rd_en) exp_rd = model_read(addr);
    for (int b = 0; b < 3; b++) begin
      logic [31:0] clr;
      clr = (wr_en && addr == ADDRS[2 + 2*b]) ? wr_data : 32'h0;
      c[b] = (c[b] & ~clr) | ev[b];
      if (wr_en && addr == ADDRS[3 + 2*b]) m[b] = wr_data;
    end
    if (wr_en && addr == 16'h8000) ctl = wr_data & 32'hF4;
    mdl = dl; mphy = phy;
    #1;
    check({req, " irq R6"}, 32'(irq), 32'(exp_irq()));
    check({req, " err_irq R7"}, 32'(err_irq), 32'(|(c[2] & m[2])));
    check({req, " link_up R8"}, 32'(link_up), 32'(mdl & mphy));
    check({req, " ctrl R9"}, {27'h0, ltssm_en, dev_mode}, {27'h0, ctl[2], ctl[7:4]});
    check({req, " rd_data R10"}, rd_data, exp_rd);
    @(negedge clk);
    wr_en = 0; rd_en = 0; evt1 = 0; evt2 = 0; err_evt = 0; intx = 0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d, input string req);
    wr_en = 1; addr = a; wr_data = d; step(req);
  endtask
  task automatic rd(input logic [15:0] a, input string req);
    rd_en = 1; addr = a; step(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    check("R1 err_irq", 32'(err_irq), 0);
    check("R1 link_up", 32'(link_up), 0);
    check("R1 rd_data", rd_data, 0);
    check("R1 ctrl", {27'h0, ltssm_en, dev_mode}, 0);
    @(negedge clk);
    rd(16'h8020, "R1 mask1");
    check("R1 mask1 read", rd_data, 32'h0);

    // R3 INTx mapping, each alone
    wr(16'h8020, 32'hFFFF_FFFF, "R5 mask1 all");
    for (int i = 0; i < 4; i++) begin
      intx = 4'(1 << i); step("R3 intx");
      rd(16'h801C, "R3 read");
      check("R3 intx bit", rd_data, 32'(1) << (9 + i));
      check("R2 sticky irq", 32'(irq), 1);
      wr(16'h801C, rd_data, "R4 ack readback");
      check("R4 cleared irq", 32'(irq), 0);
    end

    // R4 event wins over simultaneous clear
    evt2 = 32'h5; step("R2 evt2");
    wr_en = 1; addr = 16'h8024; wr_data = 32'h5; evt2 = 32'h4; step("R4 clr+evt");
    rd(16'h8024, "R4 read");
    check("R4 evt wins", rd_data, 32'h4);
    check("R6 bank2 unmasked no irq", 32'(irq), 0);
    wr(16'h8028, 32'h4, "R5 mask2");
    check("R6 bank2 irq", 32'(irq), 1);

    // R7 zero error mask
    err_evt = 32'h8000_0001; step("R7 err evt");
    check("R7 masked err", 32'(err_irq), 0);
    wr(16'h8030, 32'h1, "R7 emask");
    check("R7 err on", 32'(err_irq), 1);

    // R8 link combinations
    for (int k = 0; k < 4; k++) begin
      dl = k[0]; phy = k[1]; step("R8 link");
      rd(16'h8008, "R8 status");
      check("R8 status bits", rd_data, (32'(k[0]) << 1) | (32'(k[1]) << 9));
    end
    wr(16'h8008, 32'hFFFF_FFFF, "R8 status write ignored");
    rd(16'h8008, "R8 status after write");

    // R9 control
    wr(16'h8000, 32'hFFFF_FFFF, "R9 ctrl all");
    rd(16'h8000, "R9 ctrl read");
    check("R9 ctrl kept bits", rd_data, 32'hF4);
    wr(16'h8000, 32'h44, "R9 root mode");
    check("R9 dev_mode", 32'(dev_mode), 4);

    // R10 unmapped
    wr(16'h8004, 32'hFFFF_FFFF, "R10 unmapped wr");
    rd(16'h8034, "R10 unmapped rd");
    check("R10 unmapped zero", rd_data, 0);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 2) evt1 = 32'(1) << $urandom_range(0, 31);
      if (r == 2) evt2 = $urandom & $urandom;
      if (r == 3) err_evt = 32'(1) << $urandom_range(0, 31);
      if (r == 4) intx = 4'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        wr_en = 1; addr = ADDRS[$urandom_range(0, 9)];
        wr_data = ($urandom_range(0, 1) == 0) ? $urandom : model_read(addr);
      end
      if ($urandom_range(0, 2) == 0) begin
        rd_en = 1; if (!wr_en) addr = ADDRS[$urandom_range(0, 9)];
      end
      if ($urandom_range(0, 15) == 0) dl = $urandom_range(0, 1) == 1;
      if ($urandom_range(0, 15) == 0) phy = $urandom_range(0, 1) == 1;
      step("random R2 R4 R5");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule